// File: doc/BRIEF.md
# One-Bit Stream Low-Pass Reconstruction Filter

This block turns a two-level, duty-cycle-modulated bit stream into signed multi-bit samples of the signal that set the duty cycle. Each accepted input bit passes through a fixed second-order recursive low-pass filter. The filter has a double zero at half the sample rate and a pair of lightly damped complex poles that sit very close to z = 1. For the default constants this gives a passband of a few kHz at a 25 MHz bit rate. The DC gain is exactly one, so the long-run average of the stream shows up directly as the output level.

Both sides of the block use valid/ready streams. An input bit is taken in any cycle where `in_valid` and `in_ready` are both high. Each taken bit yields one result on the output register in the next cycle, except the first bit after reset, which only primes the filter. `in_ready` is low only while a result sits in the output register and the consumer is not taking it. The consumer can therefore apply back-pressure for any number of cycles. While it does, the filter state stays frozen, the held result does not change, and no sample is lost or repeated.

The recursion runs on a wide fixed-point datapath. One rounding step keeps the feedback state at a fixed width. A single quantizer at the output rounds the result to a 16-bit signed word and saturates it.

Top module: `bitstream_lpf`

## Requirements
- R1: When a synchronous reset is released, all filter memory is zero, `out_valid` is low, `in_ready` is high and `out_data` is 0.
- R2: An input bit of 1 stands for +1.0 and a bit of 0 stands for −1.0. On `out_data`, +1.0 is 32768 (a two's-complement fraction with 15 fractional bits), so a stream whose mean is positive settles to a positive output.
- R3: The first bit taken after reset produces no output. Every later bit taken produces exactly one output with `out_valid` high in the following cycle, and no output appears without a bit having been taken.
- R4: `in_ready` is low exactly in the cycles where `out_valid` is high and `out_ready` is low. A bit is taken only when `in_valid` and `in_ready` are both high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle. `out_data` changes only in the cycle after a bit was taken.
- R6: The gain at DC is one. A repeating 1,1,1,0 stream (mean +0.5) reads 16384 ± 64 after 60000 bits.
- R7: Rounding is symmetric (half away from zero), both in the feedback state and at the output. From reset, the stream that is the bitwise complement of another gives exactly the negated output sequence, as long as no output saturates.
- R8: The output saturates to the range −32768 to 32767 and never wraps. An all-ones stream from reset drives the overshoot to exactly 32767, and no output in that run is negative.
- R9: An alternating 1,0 stream (the Nyquist tone) is rejected. Once the start-up transient has died away (outputs 30000 to 40000), every output lies within ±1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input bit is offered |
| in_ready | output | 1 | The block can take the offered bit this cycle |
| in_data | input | 1 | Modulated bit: 1 means +1.0, 0 means −1.0 |
| out_valid | output | 1 | `out_data` holds a result not yet taken |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 16 | Signed filtered sample, 15 fractional bits |

## Verification
Assertions check the stream rules on every cycle:
- `in_ready` drops during a stall.
- A stalled result is held unchanged.
- A result only follows a taken bit.
- Nothing appears on the output until two bits have been taken.

The numeric behaviour can only be shown by the bench's long scenarios: unity DC gain, rejection of the alternating pattern, sign-symmetric rounding and saturation without wrap. These scenarios run for tens of thousands of bits so the slow poles can settle. The rounding check compares a stream with its complement, and in the complement run the consumer stalls at random. That run therefore also shows that back-pressure neither drops nor repeats a sample.

// File: rtl/bitstream_lpf_pkg.sv
package bitstream_lpf_pkg;

  // Fractional bits of the fixed-point filter coefficients.
  localparam int COEF_FRAC = 40;
  // Signed width that holds every coefficient below.
  localparam int COEF_W = 43;

  // Feed-forward scale of the binomial numerator (1, 2, 1), times 2^COEF_FRAC.
  localparam longint COEF_B = 64'sd90859;
  // First feedback coefficient, times 2^COEF_FRAC.
  localparam longint COEF_A1 = -64'sd2198779027515;
  // Second feedback coefficient, derived so that 4*B equals 1 + A1 + A0
  // exactly, which makes the quantized DC gain exactly one.
  localparam longint COEF_A0 = 4 * COEF_B - (64'sd1 <<< COEF_FRAC) - COEF_A1;

  // Filter order and binomial tap count of the numerator.
  localparam int ORDER = 2;
  localparam int NTAP = ORDER + 1;

  // Number of taken bits before the first result is offered.
  localparam int WARM_SAMPLES = 2;

  // Binomial weight of tap i for the numerator.
  function automatic int binom(input int i);
    int r;
    r = 1;
    for (int k = 0; k < i; k++) r = r * (ORDER - k) / (k + 1);
    return r;
  endfunction

endpackage

// File: rtl/bslpf_round_sat.sv
// Drops SHIFT low bits with round-half-away-from-zero, then narrows to OUT_W
// bits, either clamping or plainly truncating.
module bslpf_round_sat #(
  parameter int IN_W = 93,
  parameter int OUT_W = 48,
  parameter int SHIFT = 40,
  parameter bit SATURATE = 1'b1
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int EW = IN_W + 1;
  localparam logic signed [EW-1:0] HALF = EW'(1) <<< (SHIFT - 1);
  localparam logic signed [EW-1:0] HI = (EW'(1) <<< (OUT_W - 1)) - EW'(1);
  localparam logic signed [EW-1:0] LO = -HI - EW'(1);

  logic                 neg;
  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] mag;
  logic signed [EW-1:0] shifted;
  logic signed [EW-1:0] rounded;

  always_comb begin
    ext     = EW'(din);
    neg     = din[IN_W-1];
    mag     = neg ? -ext : ext;
    shifted = (mag + HALF) >>> SHIFT;
    rounded = neg ? -shifted : shifted;
  end

  generate
    if (SATURATE) begin : g_clamp
      always_comb begin
        if (rounded > HI)      dout = OUT_W'(HI);
        else if (rounded < LO) dout = OUT_W'(LO);
        else                   dout = OUT_W'(rounded);
      end
    end else begin : g_wrap
      assign dout = OUT_W'(rounded);
    end
  endgenerate
endmodule

// File: rtl/bslpf_feedforward.sv
// Maps each bit to +1/-1, keeps the input delay line and forms the
// numerator term B*(x0 + 2*x1 + x2), aligned to the accumulator format.
module bslpf_feedforward
  import bitstream_lpf_pkg::*;
#(
  parameter int ACC_W = 93,
  parameter int STATE_FRAC = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] ff_term
);
  localparam int SUM_W = ORDER + 3;
  localparam logic signed [ACC_W-1:0] B_EXT = ACC_W'(COEF_B);

  typedef logic signed [1:0] lvl_t;

  lvl_t                 x_now;
  lvl_t                 x_dly [ORDER];
  logic signed [SUM_W-1:0] tap_val [NTAP];
  logic signed [SUM_W-1:0] ff_sum;

  assign x_now = bit_in ? 2'sd1 : -2'sd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ORDER; i++) x_dly[i] <= '0;
    end else if (adv) begin
      x_dly[0] <= x_now;
      for (int i = 1; i < ORDER; i++) x_dly[i] <= x_dly[i-1];
    end
  end

  generate
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
      localparam logic signed [SUM_W-1:0] W = SUM_W'(binom(t));
      if (t == 0) begin : g_head
        assign tap_val[t] = W * SUM_W'(x_now);
      end else begin : g_dly
        assign tap_val[t] = W * SUM_W'(x_dly[t-1]);
      end
    end
  endgenerate

  always_comb begin
    ff_sum = '0;
    for (int t = 0; t < NTAP; t++) ff_sum = ff_sum + tap_val[t];
    ff_term = (ACC_W'(ff_sum) * B_EXT) <<< STATE_FRAC;
  end
endmodule

// File: rtl/bslpf_recursion.sv
// Feedback half of the filter: keeps two wide state words and forms
// y = ff - A1*y1 - A0*y2 at full product precision before one rounding step.
module bslpf_recursion
  import bitstream_lpf_pkg::*;
#(
  parameter int STATE_W = 48,
  parameter int ACC_W = 93
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv,
  input  logic signed [ACC_W-1:0]   ff_term,
  output logic signed [STATE_W-1:0] y_now
);
  localparam logic signed [ACC_W-1:0] A1_EXT = ACC_W'(COEF_A1);
  localparam logic signed [ACC_W-1:0] A0_EXT = ACC_W'(COEF_A0);

  logic signed [STATE_W-1:0] y_hist [ORDER];
  logic signed [ACC_W-1:0]   fb1;
  logic signed [ACC_W-1:0]   fb0;
  logic signed [ACC_W-1:0]   acc;

  always_comb begin
    fb1 = A1_EXT * ACC_W'(y_hist[0]);
    fb0 = A0_EXT * ACC_W'(y_hist[1]);
    acc = ff_term - fb1 - fb0;
  end

  bslpf_round_sat #(
    .IN_W    (ACC_W),
    .OUT_W   (STATE_W),
    .SHIFT   (COEF_FRAC),
    .SATURATE(1'b1)
  ) u_state_round (
    .din (acc),
    .dout(y_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ORDER; i++) y_hist[i] <= '0;
    end else if (adv) begin
      y_hist[0] <= y_now;
      for (int i = 1; i < ORDER; i++) y_hist[i] <= y_hist[i-1];
    end
  end
endmodule

// File: rtl/bitstream_lpf.sv
module bitstream_lpf
  import bitstream_lpf_pkg::*;
#(
  parameter int OUT_W = 16,
  parameter int STATE_W = 48,
  parameter int STATE_FRAC = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int ACC_W = COEF_W + STATE_W + 2;
  localparam int OUT_SHIFT = STATE_FRAC - (OUT_W - 1);
  localparam int WARM_W = $clog2(WARM_SAMPLES + 1);

  logic                      take;
  logic                      primed;
  logic [WARM_W-1:0]         warm;
  logic signed [ACC_W-1:0]   ff_term;
  logic signed [STATE_W-1:0] y_now;
  logic signed [OUT_W-1:0]   y_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign primed   = (warm >= WARM_W'(WARM_SAMPLES - 1));

  bslpf_feedforward #(
    .ACC_W     (ACC_W),
    .STATE_FRAC(STATE_FRAC)
  ) u_ff (
    .clk    (clk),
    .rst    (rst),
    .adv    (take),
    .bit_in (in_data),
    .ff_term(ff_term)
  );

  bslpf_recursion #(
    .STATE_W(STATE_W),
    .ACC_W  (ACC_W)
  ) u_rec (
    .clk    (clk),
    .rst    (rst),
    .adv    (take),
    .ff_term(ff_term),
    .y_now  (y_now)
  );

  bslpf_round_sat #(
    .IN_W    (STATE_W),
    .OUT_W   (OUT_W),
    .SHIFT   (OUT_SHIFT),
    .SATURATE(1'b1)
  ) u_out_round (
    .din (y_now),
    .dout(y_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      warm      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take && warm != WARM_W'(WARM_SAMPLES)) warm <= warm + 1'b1;
      if (take) begin
        out_valid <= primed;
        out_data  <= y_q;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitstream_lpf_chk.sv
module bitstream_lpf_chk #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_data
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 2'd0;
    else if (in_valid && in_ready && seen != 2'd2) seen <= seen + 2'd1;
  end

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);  // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R5

  AST_DATA_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> $past(in_valid && in_ready));  // R5

  AST_RESULT_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));  // R3

  AST_WARMUP_SILENT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen == 2'd2));  // R3
endmodule

bind bitstream_lpf bitstream_lpf_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/tb_bitstream_lpf.sv
module tb_bitstream_lpf;
  localparam int MIRROR_N = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_data = 1'b0;
  logic               out_ready = 1'b1;
  logic               in_ready;
  logic               out_valid;
  logic signed [15:0] out_data;

  bitstream_lpf dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  int checks = 0;
  int fails = 0;
  int nout, last_v, vmin, vmax, tail_abs, tail_from, slot;
  int hold_err, ready_err, prev_data;
  bit stall_prev;
  logic [15:0] lfsr = 16'hACE1;
  int rec0 [MIRROR_N];
  int rec1 [MIRROR_N];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic bit pat(input int mode, input int k);
    case (mode)
      0: return (k % 2) == 0;   // 1,0 alternating
      1: return (k % 4) != 3;   // 1,1,1,0
      2: return (k % 4) == 3;   // complement 0,0,0,1
      default: return 1'b1;     // all ones
    endcase
  endfunction

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic observe();
    int v;
    if (stall_prev && !(out_valid && int'(out_data) == prev_data)) hold_err++;
    if (out_valid && !out_ready && in_ready) ready_err++;
    stall_prev = out_valid && !out_ready;
    prev_data = int'(out_data);
    if (out_valid && out_ready) begin
      v = int'(out_data);
      last_v = v;
      if (v < vmin) vmin = v;
      if (v > vmax) vmax = v;
      if (nout >= tail_from && (v > tail_abs || -v > tail_abs))
        tail_abs = (v < 0) ? -v : v;
      if (nout < MIRROR_N) begin
        if (slot == 0) rec0[nout] = v;
        if (slot == 1) rec1[nout] = v;
      end
      nout++;
    end
  endtask

  task automatic run(input int mode, input int nacc, input bit toggle,
                     input int rslot, input int tfrom);
    int acc;
    acc = 0; nout = 0; vmin = 40000; vmax = -40000; tail_abs = 0;
    tail_from = tfrom; slot = rslot; stall_prev = 1'b0;
    hold_err = 0; ready_err = 0;
    while (acc < nacc) begin
      @(negedge clk);
      if (toggle) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] | lfsr[1];
      end else begin
        out_ready = 1'b1;
      end
      in_valid = 1'b1;
      in_data = pat(mode, acc);
      #1;
      observe();
      if (in_valid && in_ready) acc++;
    end
    repeat (2) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      #1;
      observe();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int mism, first_bad;
    // R1: state right after reset release
    reset_dut();
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_data == 16'sd0, "R1", "out_data after reset", out_data, 0);

    // R3: first taken bit only primes, second yields a result
    @(negedge clk); in_valid = 1'b1; in_data = 1'b1; out_ready = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R3", "valid after first bit", out_valid, 0);
    @(negedge clk); in_valid = 1'b0; #1;
    check(out_valid == 1'b1, "R3", "valid after second bit", out_valid, 1);

    // R9: alternating stream rejected once settled
    reset_dut();
    run(0, 40000, 1'b0, -1, 30000);
    check(tail_abs <= 1, "R9", "max |out| on 1,0 stream", tail_abs, 1);

    // R6 and R2: mean +0.5 settles to half of full scale
    reset_dut();
    run(1, 60000, 1'b0, -1, 0);
    check(last_v >= 16320 && last_v <= 16448, "R6", "75% duty settled", last_v, 16384);
    check(last_v > 0, "R2", "positive mean gives positive output", last_v, 16384);

    // R7: complement stream gives exact negation; second run stalls at random
    reset_dut();
    run(1, MIRROR_N + 1, 1'b0, 0, 0);
    check(nout == MIRROR_N, "R3", "one result per later bit", nout, MIRROR_N);
    reset_dut();
    run(2, MIRROR_N + 1, 1'b1, 1, 0);
    check(nout == MIRROR_N, "R3", "no loss under back-pressure", nout, MIRROR_N);
    check(hold_err == 0, "R5", "held result changed during stall", hold_err, 0);
    check(ready_err == 0, "R4", "in_ready high during stall", ready_err, 0);
    mism = 0; first_bad = -1;
    for (int k = 0; k < MIRROR_N; k++) begin
      if (rec1[k] != -rec0[k]) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
    end
    if (first_bad < 0) first_bad = 0;
    check(mism == 0, "R7", "complement output at first mismatch",
          rec1[first_bad], -rec0[first_bad]);
    check(rec0[MIRROR_N-1] > 0 && rec0[MIRROR_N-1] < 32767, "R7",
          "mirror run left the saturation range", rec0[MIRROR_N-1], 1);

    // R8: all-ones overshoot clamps, never wraps
    reset_dut();
    run(3, 15000, 1'b0, -1, 0);
    check(vmax == 32767, "R8", "peak of all-ones run", vmax, 32767);
    check(vmin >= 0, "R8", "minimum of all-ones run", vmin, 0);

    finish_up();
  end
endmodule